// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block turns one 128-bit plaintext block and a 128-bit key into a 128-bit ciphertext block with AES-128 in the forward direction. Each block is encrypted directly, with no chaining, which is the electronic code book use. The datapath is iterative. It applies the whitening key addition when the block is loaded, then runs ten rounds over a single state register. The last round skips the column mixing step.

A parameter sets how many clock cycles one round takes: 1, 2 or 4. With 2 or 4, a narrow S-box group substitutes one column slice of the state per cycle, and the full state is rewritten on the last slice of the round. The round key for each round is derived in the same cycles as that round, so no key schedule pass runs ahead of the data.

A block is accepted when `in_valid_i` and `in_ready_o` are both high. It takes one load cycle plus ten rounds of cycles. The result is then held on the output until it is taken with `out_ready_i`.

Top module: `aes_blk_enc`

## Requirements
- R1: While reset is asserted and after it is released, `in_ready_o` is 1 and `out_valid_o` is 0.
- R2: `cipher_o` equals the AES-128 encryption of `text_i` under `key_i`. In all three vectors the first byte of the AES byte order sits in bits 127:120.
- R3: Key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: `out_valid_o` first rises 10*CPR+1 cycles after the acceptance cycle, for CPR of 4, 2 and 1.
- R5: `in_ready_o` is low from the cycle after acceptance until the result is presented.
- R6: While `out_valid_o` is high and `out_ready_i` is low, `cipher_o` and `out_valid_o` do not change.
- R7: When a result is taken and no new block arrives in that cycle, the next cycle shows `out_valid_o` 0 and `in_ready_o` 1.
- R8: Values on `key_i`, `text_i` and `in_valid_i` while `in_ready_o` is low have no effect on the result in progress.
- R9: With `out_ready_i` held high, `in_ready_o` is high in the cycle the result is presented, so a new block is accepted then. Back-to-back blocks are therefore accepted every 10*CPR+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Key and plaintext are valid |
| in_ready_o | output | 1 | Block can accept a new input |
| key_i | input | 128 | Cipher key |
| text_i | input | 128 | Plaintext block |
| out_valid_o | output | 1 | Ciphertext is valid |
| out_ready_i | input | 1 | Consumer takes the ciphertext |
| cipher_o | output | 128 | Ciphertext block |

## Verification
The hold and release assertions assume the consumer only drops `out_ready_i` voluntarily. They also assume inputs change only between clock edges. The bench meets both by driving every input on the falling edge. The latency assertion assumes no block is accepted while one is in flight. The stimulus keeps to that: it drives garbage on `in_valid_i`, `key_i` and `text_i` only while `in_ready_o` is low, and `out_ready_i` stays low in those windows. Three instances with 4, 2 and 1 cycles per round receive the same inputs, so each sweep covers every setting.

// File: rtl/aes_blk_pkg.sv
package aes_blk_pkg;

  localparam int unsigned NR = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} enc_st_e;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, p;
    r = 8'h00;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ p;
      p = gf_xtime(p);
    end
    return r;
  endfunction

  // a^254 == a^-1 in GF(2^8), 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r, p;
    r = 8'h01;
    p = a;
    for (int i = 1; i < 8; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_sbox_lane.sv
module aes_sbox_lane #(
  parameter int unsigned BYTES = 4
) (
  input  logic [8*BYTES-1:0] din_i,
  output logic [8*BYTES-1:0] dout_o
);
  import aes_blk_pkg::*;

  for (genvar g = 0; g < BYTES; g++) begin : g_box
    assign dout_o[8*g +: 8] = sbox(din_i[8*g +: 8]);
  end

endmodule

// File: rtl/aes_key_step.sv
module aes_key_step (
  input  logic [127:0] key_i,
  input  logic [7:0]   rcon_i,
  output logic [127:0] key_o
);
  logic [31:0] rot_w, sub_w, t_w;
  logic [31:0] n0, n1, n2, n3;

  assign rot_w = {key_i[23:0], key_i[31:24]};

  aes_sbox_lane #(.BYTES(4)) u_sub (
    .din_i  (rot_w),
    .dout_o (sub_w)
  );

  assign t_w = sub_w ^ {rcon_i, 24'h0};
  assign n0  = key_i[127:96] ^ t_w;
  assign n1  = key_i[95:64]  ^ n0;
  assign n2  = key_i[63:32]  ^ n1;
  assign n3  = key_i[31:0]   ^ n2;
  assign key_o = {n0, n1, n2, n3};

endmodule

// File: rtl/aes_mix_round.sv
module aes_mix_round (
  input  logic [127:0] sub_i,
  input  logic [127:0] rkey_i,
  input  logic         last_i,
  output logic [127:0] state_o
);
  import aes_blk_pkg::*;

  logic [7:0]   sr [16];
  logic [127:0] mixed;

  always_comb begin
    logic [7:0] a0, a1, a2, a3;
    // row r of column c comes from column (c+r)%4
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        sr[4*c+r] = sub_i[127-8*(4*((c+r)%4)+r) -: 8];
    for (int c = 0; c < 4; c++) begin
      a0 = sr[4*c];
      a1 = sr[4*c+1];
      a2 = sr[4*c+2];
      a3 = sr[4*c+3];
      if (last_i) begin
        mixed[127-32*c -: 32] = {a0, a1, a2, a3};
      end else begin
        mixed[127-32*c -: 32] = {
          gf_xtime(a0) ^ gf_xtime(a1) ^ a1 ^ a2 ^ a3,
          a0 ^ gf_xtime(a1) ^ gf_xtime(a2) ^ a2 ^ a3,
          a0 ^ a1 ^ gf_xtime(a2) ^ gf_xtime(a3) ^ a3,
          gf_xtime(a0) ^ a0 ^ a1 ^ a2 ^ gf_xtime(a3)};
      end
    end
  end

  assign state_o = mixed ^ rkey_i;

endmodule

// File: rtl/aes_blk_enc.sv
module aes_blk_enc #(
  parameter int unsigned CPR = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [127:0] key_i,
  input  logic [127:0] text_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [127:0] cipher_o
);
  import aes_blk_pkg::*;

  localparam int unsigned SLICE_W = 128 / CPR;
  localparam int unsigned SLICE_B = SLICE_W / 8;
  localparam int unsigned SLW     = (CPR > 1) ? $clog2(CPR) : 1;
  localparam int unsigned LAT     = NR * CPR + 1;

  enc_st_e              st_q;
  logic [127:0]         state_q, rk_q;
  logic [7:0]           rcon_q;
  logic [3:0]           rnd_q;
  logic [SLW-1:0]       slc_q;
  logic                 accept, last_slc, last_rnd;
  logic [SLICE_W-1:0]   slice_in, slice_sub;
  logic [127:0]         sub_full, key_next, round_out;

  assign in_ready_o  = (st_q == ST_IDLE) || (st_q == ST_DONE && out_ready_i);
  assign out_valid_o = (st_q == ST_DONE);
  assign cipher_o    = state_q;
  assign accept      = in_valid_i && in_ready_o;
  assign last_slc    = (slc_q == SLW'(CPR - 1));
  assign last_rnd    = (rnd_q == 4'(NR));

  always_comb begin
    slice_in = '0;
    for (int s = 0; s < CPR; s++)
      if (slc_q == SLW'(s)) slice_in = state_q[127-s*SLICE_W -: SLICE_W];
  end

  aes_sbox_lane #(.BYTES(SLICE_B)) u_lane (
    .din_i  (slice_in),
    .dout_o (slice_sub)
  );

  if (CPR == 1) begin : g_direct
    assign sub_full = slice_sub;
  end else begin : g_sliced
    logic [127:0] sb_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sb_q <= '0;
      end else if (st_q == ST_RUN) begin
        for (int s = 0; s < CPR; s++)
          if (slc_q == SLW'(s)) sb_q[127-s*SLICE_W -: SLICE_W] <= slice_sub;
      end
    end
    always_comb begin
      sub_full = sb_q;
      for (int s = 0; s < CPR; s++)
        if (slc_q == SLW'(s)) sub_full[127-s*SLICE_W -: SLICE_W] = slice_sub;
    end
  end

  aes_key_step u_key (
    .key_i  (rk_q),
    .rcon_i (rcon_q),
    .key_o  (key_next)
  );

  aes_mix_round u_mix (
    .sub_i   (sub_full),
    .rkey_i  (key_next),
    .last_i  (last_rnd),
    .state_o (round_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      state_q <= '0;
      rk_q    <= '0;
      rcon_q  <= 8'h01;
      rnd_q   <= 4'd1;
      slc_q   <= '0;
    end else if (accept) begin
      st_q    <= ST_RUN;
      state_q <= text_i ^ key_i;
      rk_q    <= key_i;
      rcon_q  <= 8'h01;
      rnd_q   <= 4'd1;
      slc_q   <= '0;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (last_slc) begin
            state_q <= round_out;
            rk_q    <= key_next;
            rcon_q  <= gf_xtime(rcon_q);
            slc_q   <= '0;
            if (last_rnd) st_q <= ST_DONE;
            else          rnd_q <= rnd_q + 4'd1;
          end else begin
            slc_q <= slc_q + SLW'(1);
          end
        end
        ST_DONE: if (out_ready_i) st_q <= ST_IDLE;
        default: ;
      endcase
    end
  end

  // cycle counter used only by the latency property
  logic [7:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             lat_q <= '0;
    else if (accept)         lat_q <= 8'd1;
    else if (st_q == ST_RUN) lat_q <= lat_q + 8'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |=> in_ready_o && !out_valid_o);

  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> lat_q == 8'(LAT));

  p_round_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_RUN |-> rnd_q >= 4'd1 && rnd_q <= 4'(NR) && slc_q <= SLW'(CPR - 1));

  p_busy_after_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !in_ready_o && !out_valid_o);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(cipher_o));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !in_valid_i |=> !out_valid_o && in_ready_o);

  p_chain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i |-> in_ready_o);

endmodule

// File: tb/aes_blk_enc_tb_top.sv
`timescale 1ns/1ps
module aes_blk_enc_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_ni, in_valid, out_ready;
  logic [127:0] key, text;
  logic [2:0]   rdy, vld;
  logic [127:0] dat [3];
  int           checks = 0, errors = 0;
  bit           finished = 1'b0;
  logic [7:0]   sb_t [256];
  logic [63:0]  seed = 64'h9e3779b97f4a7c15;

  aes_blk_enc #(.CPR(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(rdy[0]),
    .key_i(key), .text_i(text), .out_valid_o(vld[0]), .out_ready_i(out_ready),
    .cipher_o(dat[0]));
  aes_blk_enc #(.CPR(2)) dut_h_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(rdy[1]),
    .key_i(key), .text_i(text), .out_valid_o(vld[1]), .out_ready_i(out_ready),
    .cipher_o(dat[1]));
  aes_blk_enc #(.CPR(1)) dut_f_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(rdy[2]),
    .key_i(key), .text_i(text), .out_valid_o(vld[2]), .out_ready_i(out_ready),
    .cipher_o(dat[2]));

  function automatic int lat_of(input int k);
    return 10 * ((k == 0) ? 4 : (k == 1) ? 2 : 1) + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] t_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, p;
    r = 0;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= p;
      p = {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [127:0] ref_aes(input logic [127:0] k, input logic [127:0] p);
    logic [7:0] s [16];
    logic [7:0] w [16];
    logic [7:0] t [16];
    logic [7:0] rc;
    logic [127:0] o;
    for (int i = 0; i < 16; i++) begin
      w[i] = k[127-8*i -: 8];
      s[i] = p[127-8*i -: 8] ^ w[i];
    end
    rc = 8'h01;
    for (int rnd = 1; rnd <= 10; rnd++) begin
      w[0] ^= sb_t[w[13]] ^ rc;
      w[1] ^= sb_t[w[14]];
      w[2] ^= sb_t[w[15]];
      w[3] ^= sb_t[w[12]];
      for (int i = 4; i < 16; i++) w[i] ^= w[i-4];
      rc = t_mul(rc, 8'h02);
      for (int i = 0; i < 16; i++) s[i] = sb_t[s[i]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[4*c+r] = s[4*((c+r)%4)+r];
      for (int c = 0; c < 4; c++) begin
        if (rnd < 10) begin
          s[4*c]   = t_mul(t[4*c], 2) ^ t_mul(t[4*c+1], 3) ^ t[4*c+2] ^ t[4*c+3];
          s[4*c+1] = t[4*c] ^ t_mul(t[4*c+1], 2) ^ t_mul(t[4*c+2], 3) ^ t[4*c+3];
          s[4*c+2] = t[4*c] ^ t[4*c+1] ^ t_mul(t[4*c+2], 2) ^ t_mul(t[4*c+3], 3);
          s[4*c+3] = t_mul(t[4*c], 3) ^ t[4*c+1] ^ t[4*c+2] ^ t_mul(t[4*c+3], 2);
        end else begin
          for (int r = 0; r < 4; r++) s[4*c+r] = t[4*c+r];
        end
      end
      for (int i = 0; i < 16; i++) s[i] ^= w[i];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  task automatic next_rand(output logic [127:0] v);
    for (int h = 0; h < 2; h++) begin
      seed ^= seed << 13;
      seed ^= seed >> 7;
      seed ^= seed << 17;
      v[64*h +: 64] = seed;
    end
  endtask

  task automatic run_block(input logic [127:0] k, input logic [127:0] p,
                           input logic [127:0] exp, input bit inject, input string tag);
    int lat [3];
    logic [127:0] first [3];
    @(negedge clk);
    chk(rdy == 3'b111, "R7 idle before block", 128'(rdy), 128'h7);
    in_valid = 1'b1;
    key = k;
    text = p;
    for (int j = 0; j < 3; j++) begin
      lat[j] = 0;
      first[j] = '0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int n = 1; n <= 45; n++) begin
      for (int j = 0; j < 3; j++) begin
        if (vld[j] && lat[j] == 0) begin
          lat[j] = n;
          first[j] = dat[j];
        end else if (lat[j] != 0) begin
          chk(vld[j] && dat[j] == first[j], "R6 result held", dat[j], first[j]);
        end
        chk(!rdy[j], "R5 ready low while busy", 128'(rdy[j]), 128'h0);
      end
      // R8: garbage while busy
      if (inject && n >= 2 && n <= 6) begin
        in_valid = 1'b1;
        key = ~k;
        text = p ^ 128'(n);
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    for (int j = 0; j < 3; j++) begin
      chk(lat[j] == lat_of(j), "R4 latency", 128'(lat[j]), 128'(lat_of(j)));
      chk(first[j] == exp, tag, first[j], exp);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(vld == 3'b000 && rdy == 3'b111, "R7 release", {vld, rdy}, 128'h07);
  endtask

  task automatic stream(input logic [127:0] k, input logic [127:0] p, input logic [127:0] exp);
    int last_acc [3];
    for (int j = 0; j < 3; j++) last_acc[j] = -1;
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1;
    key = k;
    text = p;
    for (int n = 0; n < 3 * 41 + 3; n++) begin
      for (int j = 0; j < 3; j++) begin
        if (vld[j]) begin
          chk(dat[j] == exp, "R9 streamed result", dat[j], exp);
          chk(rdy[j], "R9 ready with result", 128'(rdy[j]), 128'h1);
        end
        if (rdy[j]) begin
          if (last_acc[j] >= 0)
            chk(n - last_acc[j] == lat_of(j), "R9 accept period",
                128'(n - last_acc[j]), 128'(lat_of(j)));
          last_acc[j] = n;
        end
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (45) @(negedge clk);
    chk(vld == 3'b000 && rdy == 3'b111, "R7 drained", {vld, rdy}, 128'h07);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] k, p, e;
    rst_ni = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    key = '0;
    text = '0;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, o, c;
      inv = 8'h00;
      c = 8'h63;
      for (int y = 1; y < 256; y++) if (t_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
      sb_t[x] = o;
    end
    repeat (3) @(negedge clk);
    chk(rdy == 3'b111 && vld == 3'b000, "R1 in reset", {vld, rdy}, 128'h07);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rdy == 3'b111 && vld == 3'b000, "R1 after reset", {vld, rdy}, 128'h07);

    k = 128'h000102030405060708090a0b0c0d0e0f;
    p = 128'h00112233445566778899aabbccddeeff;
    e = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    chk(ref_aes(k, p) == e, "R3 model vector", ref_aes(k, p), e);
    run_block(k, p, e, 1'b0, "R3 known vector");

    k = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    p = 128'h3243f6a8885a308d313198a2e0370734;
    e = 128'h3925841d02dc09fbdc118597196a0b32;
    chk(ref_aes(k, p) == e, "R2 model vector", ref_aes(k, p), e);
    run_block(k, p, e, 1'b1, "R8 known vector with busy garbage");

    e = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
    run_block('0, '0, e, 1'b0, "R2 all-zero vector");

    for (int b = 0; b < 16; b++) begin
      next_rand(k);
      next_rand(p);
      if (b == 3) k = '1;
      if (b == 4) p = '1;
      run_block(k, p, ref_aes(k, p), b[0], b[0] ? "R8 sweep with garbage" : "R2 sweep");
    end

    next_rand(k);
    next_rand(p);
    stream(k, p, ref_aes(k, p));

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule